// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit sits between a register file and a word-addressed data memory and performs single-register loads and stores. Each request gives a base register value, a signed immediate offset, an operation code, store data and a writeback flag. The unit adds the offset to the base to form the access byte address. It drives the word address, the byte-lane write enables and the store data to the memory in the same cycle as the request.

The memory read is synchronous. On the cycle after a load request, the unit takes the returned word and picks the byte or halfword lane from the low address bits. It then extends the lane to 32 bits, with zero or sign fill as the operation selects. On that same cycle, if writeback was requested, it presents the computed address as the new base value with a write strobe for the register file. The unit uses little-endian lane order. It ignores misaligned low address bits rather than faulting.

Top module: `lsu_unit`

## Requirements
- R1: The access byte address is base_in plus ofs_in sign-extended to 32 bits. mem_addr carries bits [ADDR_W+1:2] of that address, and mem_en is high in the same cycle for any request other than code 7.
- R2: Operation codes are: 0 word load, 1 halfword load, 2 unsigned byte load, 3 signed byte load, 4 word store, 5 halfword store, 6 byte store. Code 7 makes no memory access (mem_en and mem_we low), gives no ld_valid and gives no base_we, even with wb_en high.
- R3: A word load returns the whole memory word on ld_data, with ld_valid high, exactly one cycle after the request.
- R4: A halfword load selects bits [15:0] of the word when address bit 1 is 0 and bits [31:16] when it is 1. The upper 16 bits of the result are zero.
- R5: An unsigned byte load selects byte lane N (bits [8N+7:8N]), where N is address bits [1:0]. The upper 24 bits of the result are zero.
- R6: A signed byte load selects the lane as in R5 and copies bit 7 of the selected byte into result bits [31:8].
- R7: A word store drives mem_we = 4'b1111 and mem_wdata = st_data.
- R8: A halfword store drives mem_we = 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. mem_wdata holds st_data[15:0] in both halves.
- R9: A byte store drives a single mem_we bit, bit N for address bits [1:0] = N. mem_wdata holds st_data[7:0] copied into all four bytes.
- R10: If wb_en is high on a load or store request, base_we is high one cycle later and base_out equals the access byte address. If wb_en is low, base_we stays low and the base is left unchanged.
- R11: Load requests drive mem_we = 0. Store requests do not raise ld_valid.
- R12: After reset and with no request, ld_valid, base_we, mem_en and mem_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R2) |
| base_in | input | 32 | Base register value |
| ofs_in | input | OFS_W | Signed immediate offset |
| wb_en | input | 1 | Write the computed address back to the base |
| st_data | input | 32 | Store source register value |
| mem_en | output | 1 | Memory access enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read word, one cycle after mem_en |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| base_we | output | 1 | Base register write strobe |
| base_out | output | 32 | Updated base value |

## Verification
The bound checker watches the lane-enable shapes of every store on every cycle. It also checks that loads never write, that each load or writeback request is answered one cycle later, and that the upper bits of halfword and byte results are zero-filled or sign-filled. Whether the right lane was chosen, whether stored bytes reach the right place in memory, and whether the base value is the correct sum can only be seen in the bench's scenarios. There, loads are compared against a shadow copy of memory that the bench keeps, and each base value is compared with its own address sum.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int DW    = 32;
    localparam int LANES = DW / 8;

    typedef enum logic [2:0] {
        OP_LW   = 3'd0,
        OP_LH   = 3'd1,
        OP_LBU  = 3'd2,
        OP_LBS  = 3'd3,
        OP_SW   = 3'd4,
        OP_SH   = 3'd5,
        OP_SB   = 3'd6,
        OP_NONE = 3'd7
    } lsu_op_e;

    typedef struct packed {
        logic          load;
        logic          wb;
        lsu_op_e       op;
        logic [1:0]    lane;
        logic [DW-1:0] addr;
    } lsu_rsp_t;

    function automatic logic is_store(lsu_op_e op);
        return (op == OP_SW) || (op == OP_SH) || (op == OP_SB);
    endfunction

    function automatic logic is_load(lsu_op_e op);
        return !op[2];
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic [DW-1:0]    base,
    input  logic [OFS_W-1:0] ofs,
    output logic [DW-1:0]    addr
);
    localparam int PAD = DW - OFS_W;

    logic [DW-1:0] ofs_ext;

    always_comb begin
        ofs_ext = {{PAD{ofs[OFS_W-1]}}, ofs};
        addr    = base + ofs_ext;
    end
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt
    import lsu_pkg::*;
(
    input  lsu_op_e          op,
    input  logic [1:0]       lane,
    input  logic [DW-1:0]    src,
    output logic [LANES-1:0] we,
    output logic [DW-1:0]    wdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (op)
                OP_SW:   we[i] = 1'b1;
                OP_SH:   we[i] = ((i / 2) == int'(lane[1]));
                OP_SB:   we[i] = (i == int'(lane));
                default: we[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        unique case (op)
            OP_SH:   wdata = {2{src[15:0]}};
            OP_SB:   wdata = {LANES{src[7:0]}};
            default: wdata = src;
        endcase
    end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
    import lsu_pkg::*;
(
    input  lsu_op_e       op,
    input  logic [1:0]    lane,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] data
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        byte_sel = rdata[8*lane +: 8];
        half_sel = lane[1] ? rdata[31:16] : rdata[15:0];
        unique case (op)
            OP_LH:   data = {16'd0, half_sel};
            OP_LBU:  data = {24'd0, byte_sel};
            OP_LBS:  data = {{24{byte_sel[7]}}, byte_sel};
            default: data = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [31:0]       base_in,
    input  logic [OFS_W-1:0]  ofs_in,
    input  logic              wb_en,
    input  logic [31:0]       st_data,
    output logic              mem_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_we,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              ld_valid,
    output logic [31:0]       ld_data,
    output logic              base_we,
    output logic [31:0]       base_out
);
    localparam int WORD_LSB = $clog2(LANES);

    lsu_op_e          op;
    logic             active;
    logic [DW-1:0]    addr;
    logic [LANES-1:0] fmt_we;
    lsu_rsp_t         rsp_q;

    assign op     = lsu_op_e'(req_op);
    assign active = req_valid && (op != OP_NONE);

    lsu_agen #(.OFS_W(OFS_W)) u_agen (
        .base (base_in),
        .ofs  (ofs_in),
        .addr (addr)
    );

    lsu_store_fmt u_sfmt (
        .op    (op),
        .lane  (addr[1:0]),
        .src   (st_data),
        .we    (fmt_we),
        .wdata (mem_wdata)
    );

    assign mem_en   = active;
    assign mem_addr = addr[ADDR_W+WORD_LSB-1:WORD_LSB];
    assign mem_we   = (active && is_store(op)) ? fmt_we : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.load <= active && is_load(op);
            rsp_q.wb   <= active && wb_en;
            rsp_q.op   <= op;
            rsp_q.lane <= addr[1:0];
            rsp_q.addr <= addr;
        end
    end

    lsu_load_ext u_lext (
        .op    (rsp_q.op),
        .lane  (rsp_q.lane),
        .rdata (mem_rdata),
        .data  (ld_data)
    );

    assign ld_valid = rsp_q.load;
    assign base_we  = rsp_q.wb;
    assign base_out = rsp_q.addr;
endmodule

// File: rtl/lsu_chk.sv
module lsu_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_op,
    input logic        wb_en,
    input logic        mem_en,
    input logic [3:0]  mem_we,
    input logic [31:0] mem_wdata,
    input logic        ld_valid,
    input logic [31:0] ld_data,
    input logic        base_we
);
    logic is_ld_req, is_st_req, is_wb_req;
    assign is_ld_req = req_valid && !req_op[2];
    assign is_st_req = req_valid && req_op[2] && (req_op != 3'd7);
    assign is_wb_req = (is_ld_req || is_st_req) && wb_en;

    // R11
    load_no_we_chk: assert property (@(posedge clk) disable iff (rst)
        is_ld_req |-> (mem_we == 4'd0));

    // R2
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd7) |-> (!mem_en && mem_we == 4'd0));

    // R7
    word_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd4) |-> (mem_we == 4'b1111));

    // R8
    half_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd5) |->
            ((mem_we == 4'b0011 || mem_we == 4'b1100) &&
             mem_wdata[31:16] == mem_wdata[15:0]));

    // R9
    byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd6) |->
            ($countones(mem_we) == 1 && mem_wdata == {4{mem_wdata[7:0]}}));

    // R3
    load_resp_chk: assert property (@(posedge clk) disable iff (rst)
        is_ld_req |=> ld_valid);

    // R11
    store_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !is_ld_req |=> !ld_valid);

    // R10
    wb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        is_wb_req |=> base_we);

    // R10
    wb_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !is_wb_req |=> !base_we);

    // R4
    half_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd1) |=> (ld_data[31:16] == 16'd0));

    // R5
    ubyte_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd2) |=> (ld_data[31:8] == 24'd0));

    // R6
    sbyte_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd3) |=> (ld_data[31:8] == {24{ld_data[7]}}));
endmodule

bind lsu_unit lsu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .wb_en     (wb_en),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .ld_valid  (ld_valid),
    .ld_data   (ld_data),
    .base_we   (base_we)
);

// File: tb/tb_lsu_unit.sv
module tb_lsu_unit;
    localparam int ADDR_W = 10;
    localparam int OFS_W  = 12;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = 3'd7;
    logic [31:0]       base_in = '0;
    logic [OFS_W-1:0]  ofs_in = '0;
    logic              wb_en = 1'b0;
    logic [31:0]       st_data = '0;
    logic              mem_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [3:0]        mem_we;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              ld_valid;
    logic [31:0]       ld_data;
    logic              base_we;
    logic [31:0]       base_out;

    logic [31:0] mem    [DEPTH];
    logic [31:0] shadow [DEPTH];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    lsu_unit #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) dut (
        .clk, .rst, .req_valid, .req_op, .base_in, .ofs_in, .wb_en, .st_data,
        .mem_en, .mem_addr, .mem_we, .mem_wdata, .mem_rdata,
        .ld_valid, .ld_data, .base_we, .base_out
    );

    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= mem[mem_addr];
            for (int i = 0; i < 4; i++)
                if (mem_we[i]) mem[mem_addr][8*i +: 8] <= mem_wdata[8*i +: 8];
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_addr(logic [31:0] b, logic [OFS_W-1:0] o);
        return b + 32'($signed(o));
    endfunction

    function automatic logic [3:0] f_we(logic [2:0] op, logic [1:0] ln);
        case (op)
            3'd4: return 4'b1111;
            3'd5: return ln[1] ? 4'b1100 : 4'b0011;
            3'd6: return 4'b0001 << ln;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] f_wdata(logic [2:0] op, logic [31:0] d);
        case (op)
            3'd5: return {d[15:0], d[15:0]};
            3'd6: return {d[7:0], d[7:0], d[7:0], d[7:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] f_load(logic [2:0] op, logic [1:0] ln, logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*ln +: 8];
        h = ln[1] ? w[31:16] : w[15:0];
        case (op)
            3'd1: return {16'd0, h};
            3'd2: return {24'd0, b};
            3'd3: return {{24{b[7]}}, b};
            default: return w;
        endcase
    endfunction

    function automatic string rq_of(logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic issue(logic [2:0] op, logic [31:0] b, logic [OFS_W-1:0] o,
                         logic wb, logic [31:0] sd);
        logic [31:0]       a;
        logic [ADDR_W-1:0] wi;
        logic [3:0]        we;
        logic [31:0]       exp_ld;
        logic              act;
        a   = f_addr(b, o);
        wi  = a[ADDR_W+1:2];
        act = (op != 3'd7);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; base_in = b; ofs_in = o;
        wb_en = wb; st_data = sd;
        #1;
        chk("R2 mem_en", 32'(mem_en), 32'(act));
        if (act) chk("R1 mem_addr", 32'(mem_addr), 32'(wi));
        we = act ? f_we(op, a[1:0]) : 4'd0;
        case (op)
            3'd4: chk("R7 mem_we", 32'(mem_we), 32'(we));
            3'd5: chk("R8 mem_we", 32'(mem_we), 32'(we));
            3'd6: chk("R9 mem_we", 32'(mem_we), 32'(we));
            3'd7: chk("R2 mem_we", 32'(mem_we), 32'(we));
            default: chk("R11 mem_we", 32'(mem_we), 32'(we));
        endcase
        if (op == 3'd4) chk("R7 mem_wdata", mem_wdata, f_wdata(op, sd));
        if (op == 3'd5) chk("R8 mem_wdata", mem_wdata, f_wdata(op, sd));
        if (op == 3'd6) chk("R9 mem_wdata", mem_wdata, f_wdata(op, sd));
        exp_ld = f_load(op, a[1:0], shadow[wi]);
        if (act && op[2])
            for (int i = 0; i < 4; i++)
                if (we[i]) shadow[wi][8*i +: 8] = f_wdata(op, sd) >> (8 * i);
        @(negedge clk);
        chk(act && !op[2] ? "R3 ld_valid" : "R11 ld_valid",
            32'(ld_valid), 32'(act && !op[2]));
        if (act && !op[2]) chk(rq_of(op), ld_data, exp_ld);
        chk("R10 base_we", 32'(base_we), 32'(act && wb));
        if (act && wb) chk("R10 base_out", base_out, a);
        req_valid = 1'b0; req_op = 3'd7; wb_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]    = 32'h9E37_79B9 * (i + 1);
            shadow[i] = mem[i];
        end
        process::self().srandom(32'd2024);
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 reset state
        chk("R12 ld_valid", 32'(ld_valid), 32'd0);
        chk("R12 base_we", 32'(base_we), 32'd0);
        chk("R12 mem_en", 32'(mem_en), 32'd0);
        chk("R12 mem_we", 32'(mem_we), 32'd0);

        // R10 pre-indexed word load with writeback, offset 4 from 0x7000
        issue(3'd0, 32'h0000_7000, 12'd4, 1'b1, 32'd0);
        // R3 plain word load, base unchanged
        issue(3'd0, 32'h0000_7000, 12'd0, 1'b0, 32'd0);
        // R1 negative offset with writeback
        issue(3'd0, 32'h0000_0100, 12'hFFC, 1'b1, 32'd0);
        // R9 byte stores into each lane, then read back word
        for (int l = 0; l < 4; l++)
            issue(3'd6, 32'h0000_0200, 12'(l), 1'b0, 32'h0000_0080 + 32'(l));
        issue(3'd0, 32'h0000_0200, 12'd0, 1'b0, 32'd0);
        // R6 / R5 negative byte in each lane
        for (int l = 0; l < 4; l++) begin
            issue(3'd3, 32'h0000_0200, 12'(l), 1'b0, 32'd0);
            issue(3'd2, 32'h0000_0200, 12'(l), 1'b1, 32'd0);
        end
        // R8 / R4 halfword lanes
        issue(3'd5, 32'h0000_0300, 12'd2, 1'b0, 32'h1234_ABCD);
        issue(3'd5, 32'h0000_0300, 12'd0, 1'b0, 32'h5678_8001);
        issue(3'd1, 32'h0000_0300, 12'd2, 1'b0, 32'd0);
        issue(3'd1, 32'h0000_0300, 12'd0, 1'b0, 32'd0);
        issue(3'd0, 32'h0000_0300, 12'd0, 1'b0, 32'd0);
        // R7 word store with writeback, read back
        issue(3'd4, 32'h0000_0400, 12'd8, 1'b1, 32'hDEAD_BEEF);
        issue(3'd0, 32'h0000_0408, 12'd0, 1'b0, 32'd0);
        // R2 code 7 with writeback requested
        issue(3'd7, 32'h0000_0500, 12'd4, 1'b1, 32'hFFFF_FFFF);

        for (int k = 0; k < 600; k++) begin
            logic [2:0]  op;
            logic [31:0] b;
            logic [OFS_W-1:0] o;
            op = 3'($urandom_range(0, 7));
            b  = 32'($urandom_range(32'h200, 32'hDFF));
            o  = 12'($signed($urandom_range(0, 1023)) - 512);
            issue(op, b, o, 1'($urandom_range(0, 1)), $urandom);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule